// File: doc/BRIEF.md
# Coprocessor command register with busy handshake

This block is a 16-bit command register that sits between a host bus and a command executor inside a communication coprocessor. Software writes one word holding an opcode, a channel number, a reset request and a busy flag. When the flag bit is written as 1 and the block is idle, the block latches the opcode and channel. It then gives the executor a one-cycle strobe and keeps the flag reading as 1 until the executor returns an acknowledge. Software finds out that a command has finished by polling the flag until hardware clears it.

A reset request uses the same register. When the reset bit and the flag bit are written together, the block drives an internal reset output for a fixed number of cycles, and this overrides any command still in flight. The flag reads back as 1 until the pulse ends. A command word with reserved bits set does not start. It sets a sticky error bit in the readback instead.

Top module: `cmd_reg_hs`

## Requirements
- R1: After reset, rd_data reads 16'h0000, and both cmd_valid and core_rst are low.
- R2: A write with bit 0 = 1, bit 15 = 0 and the reserved bits (14:12 and 3:1) clear, made while busy reads 0, starts a command. In the cycle after the write edge, cmd_valid is high, cmd_opcode equals data bits 11:8, cmd_channel equals bits 7:4, and rd_data shows bit 0 = 1, bits 11:8 = opcode and bits 7:4 = channel.
- R3: cmd_valid is high for exactly one cycle per started command.
- R4: Busy (rd_data bit 0) stays 1 while cmd_ack is low. It reads 0 in the cycle after the edge that samples cmd_ack high.
- R5: While busy is 1, a write without bit 15 is ignored: cmd_valid stays low and rd_data is unchanged.
- R6: A command write with any reserved bit set does not start. Busy stays 0, cmd_valid stays low, and rd_data bit 1 (the illegal-write flag) becomes 1. The next accepted command clears that flag.
- R7: A write with bit 0 = 0 has no effect.
- R8: A write with bits 15 and 0 both set holds core_rst high for RST_CYCLES (default 16) cycles, starting in the cycle after the write edge. During that time rd_data bits 15 and 0 read 1. Both clear in the cycle after core_rst falls, and the latched opcode and channel are kept.
- R9: A reset write is taken even while a command is busy. While core_rst is high, cmd_ack is ignored and busy stays 1.
- R10: cmd_ack while idle has no effect on rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Command word written |
| rd_data | output | 16 | Readback: busy, illegal flag, channel, opcode, reset in progress |
| cmd_valid | output | 1 | One-cycle command strobe to the executor |
| cmd_opcode | output | 4 | Latched opcode |
| cmd_channel | output | 4 | Latched channel |
| cmd_ack | input | 1 | Executor completion acknowledge |
| core_rst | output | 1 | Internal coprocessor reset pulse |

## Verification
Every result is registered once after the edge that samples its cause. The bench drives on the falling edge and samples on the next falling edge, one rising edge later:

- For a write, cmd_valid, the latched fields and the readback are due at that next falling edge.
- After an acknowledge, the busy clear is due one sample later.
- For a reset, core_rst must be high on exactly RST_CYCLES consecutive samples, with busy clear on the first sample after that.

Completion is waited for through a poll of the readback with a 10000-read limit, the same rule software uses.

// File: rtl/cmdreg_pkg.sv
`timescale 1ns/1ps
package cmdreg_pkg;
  localparam int WORD_W   = 16;
  localparam int BUSY_BIT = 0;
  localparam int ILL_BIT  = 1;
  localparam int RST_BIT  = 15;
  localparam int OPC_LSB  = 8;
  localparam int OPC_W    = 4;
  localparam int CH_LSB   = 4;
  localparam int CH_W     = 4;

  typedef enum logic [1:0] {WR_NONE, WR_CMD, WR_RST, WR_BAD} wr_kind_e;

  function automatic logic [WORD_W-1:0] used_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    m[BUSY_BIT] = 1'b1;
    m[RST_BIT]  = 1'b1;
    for (int i = 0; i < OPC_W; i++) m[OPC_LSB+i] = 1'b1;
    for (int i = 0; i < CH_W; i++)  m[CH_LSB+i]  = 1'b1;
    return m;
  endfunction

  function automatic logic has_rsvd(input logic [WORD_W-1:0] w);
    return |(w & ~used_mask());
  endfunction

  function automatic wr_kind_e classify(input logic en, input logic [WORD_W-1:0] w,
                                        input logic busy);
    if (!en || !w[BUSY_BIT]) return WR_NONE;
    if (w[RST_BIT])          return WR_RST;
    if (busy)                return WR_NONE;
    if (has_rsvd(w))         return WR_BAD;
    return WR_CMD;
  endfunction
endpackage

// File: rtl/cmd_decode.sv
`timescale 1ns/1ps
module cmd_decode
  import cmdreg_pkg::*;
(
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              busy,
  output wr_kind_e          kind,
  output logic [OPC_W-1:0]  opc,
  output logic [CH_W-1:0]   ch
);
  always_comb begin
    kind = classify(wr_en, wr_data, busy);
    opc  = wr_data[OPC_LSB +: OPC_W];
    ch   = wr_data[CH_LSB +: CH_W];
  end
endmodule

// File: rtl/rst_seq.sv
`timescale 1ns/1ps
module rst_seq #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
  assign done   = (cnt_q == CNT_W'(1)) && !start;

  p_load_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == CNT_LOAD));
  p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cmd_track.sv
`timescale 1ns/1ps
module cmd_track
  import cmdreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  wr_kind_e         kind,
  input  logic [OPC_W-1:0] opc_in,
  input  logic [CH_W-1:0]  ch_in,
  input  logic             ack,
  input  logic             rst_active,
  input  logic             rst_done,
  output logic             busy,
  output logic             valid,
  output logic             ill,
  output logic [OPC_W-1:0] opc,
  output logic [CH_W-1:0]  ch
);
  logic busy_q, valid_q, ill_q;
  logic [OPC_W-1:0] opc_q;
  logic [CH_W-1:0]  ch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      ill_q   <= 1'b0;
      opc_q   <= '0;
      ch_q    <= '0;
    end else begin
      valid_q <= (kind == WR_CMD);
      if (kind == WR_RST)       busy_q <= 1'b1;
      else if (rst_active)      busy_q <= !rst_done;
      else if (kind == WR_CMD)  busy_q <= 1'b1;
      else if (busy_q && ack)   busy_q <= 1'b0;
      if (kind == WR_CMD) begin
        opc_q <= opc_in;
        ch_q  <= ch_in;
        ill_q <= 1'b0;
      end else if (kind == WR_BAD) begin
        ill_q <= 1'b1;
      end
    end
  end

  assign busy  = busy_q;
  assign valid = valid_q;
  assign ill   = ill_q;
  assign opc   = opc_q;
  assign ch    = ch_q;

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ack && !rst_active && kind != WR_RST) |=> !busy_q);
  p_busy_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ack && !rst_done) |=> busy_q);
  p_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WR_BAD) |=> (ill_q && !busy_q && !valid_q));
  p_rst_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active |-> busy_q);
endmodule

// File: rtl/cmd_reg_hs.sv
`timescale 1ns/1ps
module cmd_reg_hs
  import cmdreg_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              cmd_valid,
  output logic [OPC_W-1:0]  cmd_opcode,
  output logic [CH_W-1:0]   cmd_channel,
  input  logic              cmd_ack,
  output logic              core_rst
);
  wr_kind_e         wr_kind;
  logic [OPC_W-1:0] dec_opc;
  logic [CH_W-1:0]  dec_ch;
  logic             busy, ill, rst_active, rst_done, rst_start;

  cmd_decode u_dec (
    .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
    .kind(wr_kind), .opc(dec_opc), .ch(dec_ch)
  );

  assign rst_start = (wr_kind == WR_RST);

  rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .start(rst_start),
    .active(rst_active), .done(rst_done)
  );

  cmd_track u_trk (
    .clk(clk), .rst_n(rst_n), .kind(wr_kind), .opc_in(dec_opc), .ch_in(dec_ch),
    .ack(cmd_ack), .rst_active(rst_active), .rst_done(rst_done),
    .busy(busy), .valid(cmd_valid), .ill(ill), .opc(cmd_opcode), .ch(cmd_channel)
  );

  always_comb begin
    rd_data = '0;
    rd_data[BUSY_BIT] = busy;
    rd_data[ILL_BIT]  = ill;
    rd_data[RST_BIT]  = rst_active;
    rd_data[OPC_LSB +: OPC_W] = cmd_opcode;
    rd_data[CH_LSB +: CH_W]   = cmd_channel;
  end

  assign core_rst = rst_active;

  p_busy_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[BUSY_BIT] && wr_en && !wr_data[RST_BIT]) |=> (!cmd_valid && $stable(cmd_opcode)));
  p_no_flag_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[BUSY_BIT] && wr_en && !wr_data[BUSY_BIT] && !cmd_ack) |=> $stable(rd_data));
  p_reset_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[RST_BIT] && wr_data[BUSY_BIT]) |=> (core_rst && rd_data[BUSY_BIT]));
  p_idle_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[BUSY_BIT] && cmd_ack && !wr_en) |=> $stable(rd_data));
endmodule

// File: tb/cmd_reg_hs_tb_top.sv
`timescale 1ns/1ps
module cmd_reg_hs_tb_top;
  localparam int NRST = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        cmd_valid, core_rst;
  logic [3:0]  cmd_opcode, cmd_channel;
  logic        cmd_ack = 1'b0;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  cmd_reg_hs #(.RST_CYCLES(NRST)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_channel(cmd_channel),
    .cmd_ack(cmd_ack), .core_rst(core_rst)
  );

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ack_pulse();
    @(negedge clk); cmd_ack = 1'b1;
    @(negedge clk); cmd_ack = 1'b0;
  endtask

  task automatic poll_idle(input string req);
    int n = 0;
    while (rd_data[0] && n < 10000) begin @(negedge clk); n++; end
    check(req, "poll limit", {15'd0, rd_data[0]}, 16'h0000);
  endtask

  task automatic t_reset_state();
    check("R1", "rd_data", rd_data, 16'h0000);
    check("R1", "cmd_valid", {15'd0, cmd_valid}, 16'h0000);
    check("R1", "core_rst", {15'd0, core_rst}, 16'h0000);
  endtask

  task automatic t_command();
    wr(16'h0A51);
    check("R2", "cmd_valid", {15'd0, cmd_valid}, 16'h0001);
    check("R2", "opcode", {12'd0, cmd_opcode}, 16'h000A);
    check("R2", "channel", {12'd0, cmd_channel}, 16'h0005);
    check("R2", "rd_data", rd_data, 16'h0A51);
    @(negedge clk);
    check("R3", "cmd_valid one cycle", {15'd0, cmd_valid}, 16'h0000);
    repeat (3) @(negedge clk);
    check("R4", "busy held", rd_data, 16'h0A51);
    wr(16'h0371);
    check("R5", "no strobe when busy", {15'd0, cmd_valid}, 16'h0000);
    check("R5", "rd unchanged when busy", rd_data, 16'h0A51);
    ack_pulse();
    check("R4", "busy clear after ack", rd_data, 16'h0A50);
    poll_idle("R4");
  endtask

  task automatic t_idle_ack();
    ack_pulse();
    check("R10", "idle ack", rd_data, 16'h0A50);
    @(negedge clk);
    check("R10", "idle ack no strobe", {15'd0, cmd_valid}, 16'h0000);
  endtask

  task automatic t_illegal();
    wr(16'h1031);
    check("R6", "no strobe bit12", {15'd0, cmd_valid}, 16'h0000);
    check("R6", "flag set bit12", rd_data, 16'h0A52);
    wr(16'h0039);
    check("R6", "flag set bit3", rd_data, 16'h0A52);
    wr(16'h0C31);
    check("R6", "legal cmd starts", {15'd0, cmd_valid}, 16'h0001);
    check("R6", "flag cleared", rd_data, 16'h0C31);
    ack_pulse();
    check("R4", "second ack", rd_data, 16'h0C30);
  endtask

  task automatic t_no_flag();
    wr(16'h0F70);
    check("R7", "no flag write", rd_data, 16'h0C30);
    check("R7", "no flag strobe", {15'd0, cmd_valid}, 16'h0000);
  endtask

  task automatic t_reset_idle();
    int hi = 0;
    wr(16'h8001);
    check("R8", "rd during reset", rd_data, 16'h8C31);
    while (core_rst && hi < 100) begin hi++; @(negedge clk); end
    check("R8", "pulse length", 16'(hi), 16'(NRST));
    check("R8", "rd after reset", rd_data, 16'h0C30);
  endtask

  task automatic t_reset_override();
    int hi = 0;
    wr(16'h0261);
    check("R2", "cmd before reset", rd_data, 16'h0261);
    wr(16'h8001);
    check("R9", "reset while busy", {15'd0, core_rst}, 16'h0001);
    ack_pulse();
    check("R9", "ack ignored in reset", rd_data, 16'h8261);
    while (core_rst && hi < 100) begin
      hi++;
      if (cmd_valid) check("R9", "strobe in reset", 16'h0001, 16'h0000);
      @(negedge clk);
    end
    check("R9", "busy clear after reset", rd_data, 16'h0260);
    wr(16'h0E21);
    check("R2", "cmd after reset", {12'd0, cmd_opcode}, 16'h000E);
    ack_pulse();
    poll_idle("R4");
  endtask

  initial begin
    #(8 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_command();
    t_idle_ack();
    t_illegal();
    t_no_flag();
    t_reset_idle();
    t_reset_override();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule